// File: doc/BRIEF.md
# Block-Move DMA Engine with Self-Reload

The engine copies a run of words between one peripheral and system memory so that the host processor does not have to. The host sets a start address, a word count and a control word through a four-entry register port. A peripheral then paces each word with a request/acknowledge pair. For every word the engine places an address on the memory bus and raises one strobe: a read or a write, chosen by the direction bit.

The engine can share the system bus in three ways. Burst mode requests the bus once and keeps it for the whole block. Cycle-steal mode gives the bus back after every word. Transparent mode never requests the bus. Instead it moves a word only in a cycle where the processor reports that the bus is idle.

After the final word the engine pulses an end-of-block signal and raises an interrupt, which stays up until software clears it. When self-reload is on, the start values are copied back into the working registers and the engine stays armed for the next block. When self-reload is off, the engine disarms itself.

Top module: `blkmove_dma`

## Requirements
- R1: A write to register 0 (address) or register 1 (count) loads both the stored start value and the working value. Reading registers 0 and 1 returns the working address and the working count.
- R2: Any register write made while `bus_gnt` is 1 is ignored.
- R3: Each word moved raises `dack` for one cycle and puts the working address on `mem_addr`. The address then increments by one, wrapping at 16 bits, and the count decrements by one. A programmed count of N moves exactly N words.
- R4: Control bit 2 sets the direction: 1 means memory to peripheral and pulses `mem_rd`, 0 means peripheral to memory and pulses `mem_wr`. Each strobe is raised only together with `dack`.
- R5: Burst mode (control bits 1:0 = 0) keeps `bus_req` high from the first grant until the last word, then drops it.
- R6: Cycle-steal mode (control bits 1:0 = 1) drops `bus_req` in the cycle after every word.
- R7: Transparent mode (control bits 1:0 = 2) never raises `bus_req`. It moves a word only in a cycle where `bus_idle` is 1 and `bus_gnt` is 0.
- R8: `eop` is high together with `dack` on the last word of a block, that is, when the working count is 1. `irq` rises on the next cycle and stays high until a write to register 3 with bit 0 set.
- R9: When control bit 3 (self-reload) is set, the end of a block restores the working address and count from the start values. Enable (control bit 4) stays at 1.
- R10: When self-reload is clear, the end of a block clears the enable bit. The working address is then left at start plus count, and the working count at 0.
- R11: Writes to the address or count register are ignored while the enable bit is 1.
- R12: A synchronous reset drops `bus_req`, returns the engine to idle, and clears the enable bit, the interrupt and all registers.
- R13: No word moves while `dreq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register |
| bus_req | output | 1 | Request for the system bus |
| bus_gnt | input | 1 | The system bus has been granted to the engine |
| bus_idle | input | 1 | The processor is not using the bus this cycle |
| dreq | input | 1 | The peripheral is ready for a word |
| dack | output | 1 | A word moves this cycle |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| eop | output | 1 | Last word of the block |
| irq | output | 1 | Block-complete interrupt |

## Verification
Some properties are checked on every cycle:
- the strobes always match `dack`;
- a word is never moved without either ownership of the bus or an idle cycle;
- the bus is released after each stolen word and held between burst words;
- `eop` is always followed by `irq`, and `irq` holds until it is cleared;
- writes made while the bus is granted are blocked.

Other behaviour shows only in the bench's scenarios: the exact address sequence and the word totals, the readback values after a reload or after disarming, wrap of the address past 16 bits, and the register lockout while the engine is enabled.

// File: rtl/blkmove_dma.sv
module blkmove_dma #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          bus_idle,
  input  logic          dreq,
  output logic          dack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          eop,
  output logic          irq
);
  localparam logic [1:0] M_STEAL = 2'd1;
  localparam logic [1:0] M_TRANS = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_OWN} st_t;

  st_t           state;
  logic [AW-1:0] base_addr, cur_addr;
  logic [CW-1:0] base_cnt, cur_cnt;
  logic [1:0]    mode;
  logic          dir, reload, en, done;

  wire cpu_wr = reg_wr && !bus_gnt;
  wire clr    = cpu_wr && reg_sel == 2'd3 && reg_wdata[0];
  wire last   = cur_cnt == CW'(1);
  wire xfer   = en && dreq &&
                ((state == S_OWN && bus_gnt) ||
                 (state == S_IDLE && mode == M_TRANS && bus_idle && !bus_gnt));

  assign bus_req  = state != S_IDLE;
  assign dack     = xfer;
  assign mem_addr = cur_addr;
  assign mem_rd   = xfer && dir;
  assign mem_wr   = xfer && !dir;
  assign eop      = xfer && last;
  assign irq      = done;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = 16'(cur_addr);
      2'd1:    reg_rdata = 16'(cur_cnt);
      2'd2:    reg_rdata = {11'd0, en, reload, dir, mode};
      default: reg_rdata = {15'd0, done};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      dir       <= 1'b0;
      reload    <= 1'b0;
      en        <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (cpu_wr) begin
        case (reg_sel)
          2'd0: if (!en) begin
            base_addr <= AW'(reg_wdata);
            cur_addr  <= AW'(reg_wdata);
          end
          2'd1: if (!en) begin
            base_cnt <= CW'(reg_wdata);
            cur_cnt  <= CW'(reg_wdata);
          end
          2'd2: begin
            mode   <= reg_wdata[1:0];
            dir    <= reg_wdata[2];
            reload <= reg_wdata[3];
            en     <= reg_wdata[4];
          end
          default: ;
        endcase
      end
      if (clr) done <= 1'b0;

      if (xfer) begin
        if (last) begin
          done <= 1'b1;
          if (reload) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
          end else begin
            cur_addr <= cur_addr + AW'(1);
            cur_cnt  <= '0;
            en       <= 1'b0;
          end
        end else begin
          cur_addr <= cur_addr + AW'(1);
          cur_cnt  <= cur_cnt - CW'(1);
        end
      end

      case (state)
        S_IDLE: if (en && dreq && mode != M_TRANS) state <= S_REQ;
        S_REQ:  if (!en) state <= S_IDLE;
                else if (bus_gnt) state <= S_OWN;
        S_OWN:  if (!en || (xfer && (last || mode == M_STEAL))) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkmove_dma_chk.sv
module blkmove_dma_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    reg_sel,
  input logic          reg_wr,
  input logic [15:0]   reg_wdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_idle,
  input logic          dreq,
  input logic          dack,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          eop,
  input logic          irq,
  input logic [1:0]    mode,
  input logic [CW-1:0] cur_cnt
);
  p_strobe_dack_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (dack && !(mem_rd && mem_wr)));

  p_paced_r13: assert property (@(posedge clk) disable iff (rst)
    dack |-> dreq);

  p_bus_use_r7: assert property (@(posedge clk) disable iff (rst)
    dack |-> ((bus_req && bus_gnt) || (bus_idle && !bus_req && !bus_gnt)));

  p_steal_release_r6: assert property (@(posedge clk) disable iff (rst)
    (dack && mode == 2'd1) |=> !bus_req);

  p_burst_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dack && !eop && mode == 2'd0) |=> bus_req);

  p_eop_irq_r8: assert property (@(posedge clk) disable iff (rst)
    eop |=> irq);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_wr && !bus_gnt && reg_sel == 2'd3 && reg_wdata[0])) |=> irq);

  p_grant_lock_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && bus_gnt && reg_sel == 2'd1 && !dack) |=> $stable(cur_cnt));

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!bus_req && !irq && !dack));
endmodule

bind blkmove_dma blkmove_dma_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_idle(bus_idle), .dreq(dreq),
  .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr), .eop(eop), .irq(irq),
  .mode(mode), .cur_cnt(cur_cnt)
);

// File: tb/blkmove_dma_tb.sv
module blkmove_dma_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_req, bus_gnt = 1'b0, bus_idle = 1'b0, dreq = 1'b0;
  logic        dack, mem_rd, mem_wr, eop, irq;
  logic [15:0] mem_addr;

  int n_chk = 0;
  int n_err = 0;

  // {mode[1:0], dir, reload, addr[15:0], count[15:0]}
  localparam logic [35:0] VEC [5] = '{
    {2'd0, 1'b0, 1'b0, 16'h1000, 16'd4},
    {2'd1, 1'b1, 1'b0, 16'h2FFE, 16'd3},
    {2'd2, 1'b0, 1'b0, 16'h0040, 16'd5},
    {2'd0, 1'b1, 1'b1, 16'h0100, 16'd2},
    {2'd1, 1'b0, 1'b1, 16'hFFFF, 16'd2}
  };

  blkmove_dma u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_idle(bus_idle),
    .dreq(dreq), .dack(dack), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .eop(eop), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic run_block(input logic [1:0] m, input logic d, input int cnt,
                           input logic [15:0] start, output int words);
    bit pd = 0, pe = 0, seen_eop = 0;
    int cyc = 0;
    logic [15:0] ea;
    words = 0;
    dreq = 1'b1;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      bus_gnt  = bus_req;
      bus_idle = (m == 2'd2) ? (cyc % 3 == 0) : 1'b0;
      if (seen_eop) dreq = 1'b0;
      #1;
      if (pd && m == 2'd1) chk(bus_req == 1'b0, "R6 bus_req after stolen word", int'(bus_req), 0);
      if (pd && !pe && m == 2'd0) chk(bus_req == 1'b1, "R5 bus_req held in burst", int'(bus_req), 1);
      if (pe && m == 2'd0) chk(bus_req == 1'b0, "R5 bus_req released at end", int'(bus_req), 0);
      if (m == 2'd2) chk(bus_req == 1'b0, "R7 no bus_req in transparent", int'(bus_req), 0);
      if (dack) begin
        ea = start + 16'(words);
        chk(mem_addr == ea, "R3 address sequence", int'(mem_addr), int'(ea));
        chk(mem_rd == d && mem_wr == !d, "R4 strobe direction", int'({mem_rd, mem_wr}), int'({d, !d}));
        if (m == 2'd2) chk(bus_idle == 1'b1, "R7 word only on idle cycle", int'(bus_idle), 1);
        chk(eop == (words == cnt - 1), "R8 eop on last word", int'(eop), int'(words == cnt - 1));
        if (eop) seen_eop = 1;
        words++;
      end
      pd = dack; pe = eop;
      if (irq) break;
    end
    dreq = 1'b0; bus_idle = 1'b0; bus_gnt = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int words;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    #1;
    chk(bus_req == 0 && dack == 0 && irq == 0, "R12 outputs after reset", int'({bus_req, dack, irq}), 0);
    rd(2'd2, v); chk(v == 16'h0, "R12 control after reset", int'(v), 0);
    rd(2'd0, v); chk(v == 16'h0, "R12 address after reset", int'(v), 0);

    for (int i = 0; i < 5; i++) begin
      logic [1:0]  m;
      logic        d, rl;
      logic [15:0] a, c, ea;
      {m, d, rl, a, c} = VEC[i];
      wr(2'd0, a);
      wr(2'd1, c);
      rd(2'd0, v); chk(v == a, "R1 address readback", int'(v), int'(a));
      rd(2'd1, v); chk(v == c, "R1 count readback", int'(v), int'(c));
      wr(2'd2, {11'd0, 1'b1, rl, d, m});
      run_block(m, d, int'(c), a, words);
      chk(words == int'(c), "R3 words moved", words, int'(c));
      chk(irq == 1'b1, "R8 irq after block", int'(irq), 1);
      ea = rl ? a : a + c;
      rd(2'd0, v); chk(v == ea, rl ? "R9 address reloaded" : "R10 final address", int'(v), int'(ea));
      rd(2'd1, v); chk(v == (rl ? c : 16'h0), rl ? "R9 count reloaded" : "R10 count zero", int'(v), int'(rl ? c : 16'h0));
      rd(2'd2, v); chk(v[4] == rl, rl ? "R9 enable kept" : "R10 enable cleared", int'(v[4]), int'(rl));
      repeat (2) @(negedge clk);
      chk(irq == 1'b1, "R8 irq held", int'(irq), 1);
      wr(2'd3, 16'h0001);
      #1; chk(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
      if (rl) wr(2'd2, 16'h0000);
    end

    // R11 address/count writes locked while enabled
    wr(2'd0, 16'h0500);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h0010);
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h0777);
    rd(2'd1, v); chk(v == 16'd3, "R11 count write ignored", int'(v), 3);
    rd(2'd0, v); chk(v == 16'h0500, "R11 address write ignored", int'(v), 16'h0500);

    // R13 no activity without dreq
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(dack == 0 && bus_req == 0, "R13 idle without dreq", int'({dack, bus_req}), 0);
    end

    // R2 writes ignored while granted
    @(negedge clk);
    bus_gnt = 1'b1;
    reg_sel = 2'd2; reg_wdata = 16'h0000; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; bus_gnt = 1'b0;
    rd(2'd2, v); chk(v[4] == 1'b1, "R2 control write ignored under grant", int'(v[4]), 1);

    // R12 reset in mid-block
    dreq = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      bus_gnt = bus_req;
      #1;
      if (dack) break;
    end
    chk(dack == 1'b1, "R12 block started before reset", int'(dack), 1);
    @(negedge clk);
    rst = 1'b1; dreq = 1'b0; bus_gnt = 1'b0;
    @(negedge clk); #1;
    chk(bus_req == 0 && dack == 0, "R12 bus released on reset", int'({bus_req, dack}), 0);
    rst = 1'b0;
    rd(2'd2, v); chk(v[4] == 1'b0, "R12 enable cleared", int'(v[4]), 0);
    rd(2'd1, v); chk(v == 16'h0, "R12 count cleared", int'(v), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule